// File: doc/BRIEF.md
# DMA Controller Register Port

This block is the host-facing register interface of a four-channel DMA engine. A host reaches it over an 8-bit data bus, with an active-low chip select, active-low read and write strobes and a 4-bit register address. Each channel has a 16-bit start-address register and a 16-bit count register. Both are reached one byte at a time. An internal byte pointer, not an address bit, chooses which byte. The port also holds the 8-bit mode register, which is write-only, and the sticky flag bits that the host reads back as the status byte.

The channel registers themselves sit in the engine's counter datapath. This port gives the datapath a one-cycle write pulse per register, together with the byte-select flag and the data byte. The datapath returns the current register contents on a flat bus, and the port uses that bus for reads. The engine reports terminal-count events and update-cycle start and end on plain pulse inputs. While the engine owns the system bus, it raises `master_i` and the port stops responding to chip select.

All pins are plain level or pulse signals sampled on `clk`. The host strobes carry no handshake and cannot be stalled, so there is no back-pressure at any edge. An access counts as complete in the first cycle in which its strobe is seen high again, after that strobe was seen low with chip select active and `master_i` low in the cycle before.

Top module: `dma_regport`

## Requirements
- R1: After reset, `mode_o` is 0, the byte pointer selects the low byte, all terminal-count flags and the update flag are 0, `reg_we_o` is 0 and `rd_oe_o` is 0.
- R2: A completed write with `addr_i[3]`=0 raises exactly bit `addr_i[2:0]` of `reg_we_o` for one cycle. That bit index is channel×2 plus `addr_i[0]`, where `addr_i[0]`=1 means the count register. During that cycle `reg_wdata_o` carries the written byte and `reg_hi_o` carries the byte pointer (0 = low byte).
- R3: The byte pointer toggles exactly once per completed channel-register access, read or write, however many cycles the strobe is held low. No write pulse appears while the strobe is still low.
- R4: A completed write to address 4'b1000 loads `mode_o` in the next cycle, clears the byte pointer and raises no bit of `reg_we_o`. The mode bits, from bit 7 down, are: auto-load, stop-on-terminal-count, extended write, rotating priority, and the enables of channels 3, 2, 1 and 0.
- R5: A read with `addr_i[3]`=0 returns a byte of the register at `chan_rd_i[16*addr_i[2:0] +: 16]`. The low byte is returned when the pointer is 0 and the high byte when it is 1.
- R6: A read at address 4'b1000 returns {3'b000, update flag, flags of channels 3..0}. Completing that read clears the four terminal-count flags and does not move the byte pointer.
- R7: A pulse on `tc_hit_i[n]` sets flag n, which stays set until a status read completes. A pulse that arrives in the cycle the clearing read completes leaves its flag set.
- R8: `upd_set_i` sets the update flag. `upd_clr_i`, and a mode write with bit 7 = 0, clear it; `upd_clr_i` wins over a simultaneous set. A status read leaves it unchanged.
- R9: While `master_i` is 1, chip select is ignored. `rd_oe_o` stays 0, no write pulse appears, and the mode register and byte pointer keep their values.
- R10: `rd_oe_o` is 1 only while `cs_n`=0, `ior_n`=0, `iow_n`=1 and `master_i`=0. Whenever it is 0, `rd_data_o` is 0.
- R11: Addresses 4'b1001 to 4'b1111 read as 0. Writes to them change neither the mode register nor the byte pointer, and raise no write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| ior_n | input | 1 | Active-low host read strobe |
| iow_n | input | 1 | Active-low host write strobe |
| addr_i | input | 4 | Register address |
| data_i | input | 8 | Host write data |
| master_i | input | 1 | Engine currently owns the system bus |
| tc_hit_i | input | 4 | Terminal-count event pulse, one bit per channel |
| upd_set_i | input | 1 | Update cycle entered |
| upd_clr_i | input | 1 | Update cycle finished |
| chan_rd_i | input | 128 | Current contents of the eight channel registers |
| rd_data_o | output | 8 | Read data |
| rd_oe_o | output | 1 | Read data drive enable |
| reg_we_o | output | 8 | One-hot channel-register write pulse |
| reg_hi_o | output | 1 | Byte pointer: 1 selects the high byte |
| reg_wdata_o | output | 8 | Byte to write |
| mode_o | output | 8 | Mode register |

## Verification
Some properties are checked by assertions on every cycle:
- write pulses are one-hot and last a single cycle;
- the mode register changes only right after a write strobe has closed;
- read data is zero whenever the output enable is low;
- the upper status bits read as zero;
- the port stays silent while the engine is bus master.

Other behaviour needs the bench's scenarios against its own model:
- the byte pointer's alternation across interleaved reads and writes;
- the pointer being reset by mode writes;
- the sticky flags being cleared by a status read, with a coincident event surviving;
- the update flag surviving status reads.

// File: rtl/dma_regport_pkg.sv
package dma_regport_pkg;
  localparam int CH_N   = 4;
  localparam int DATA_W = 8;
  localparam int REG_W  = 2 * DATA_W;
  localparam int ADDR_W = 4;
  localparam int NREG   = 2 * CH_N;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CHAN = 2'd1,
    TGT_GEN  = 2'd2
  } tgt_e;

  function automatic tgt_e tgt_of(input logic [ADDR_W-1:0] a);
    if (!a[ADDR_W-1])                 return TGT_CHAN;
    else if (a[ADDR_W-2:0] == '0)     return TGT_GEN;
    else                              return TGT_NONE;
  endfunction
endpackage

// File: rtl/rp_access.sv
module rp_access
  import dma_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              strobe_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q <= sel;
      if (sel) addr_q <= addr_i;
    end
  end

  assign done = act_q & strobe_n;
endmodule

// File: rtl/rp_status.sv
module rp_status
  import dma_regport_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_N-1:0] tc_hit,
  input  logic            tc_clr,
  input  logic            upd_set,
  input  logic            upd_clr,
  output logic [CH_N-1:0] tc_q,
  output logic            upd_q
);
  for (genvar g = 0; g < CH_N; g++) begin : g_tc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tc_q[g] <= 1'b0;
      else if (tc_hit[g]) tc_q[g] <= 1'b1;
      else if (tc_clr)    tc_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       upd_q <= 1'b0;
    else if (upd_clr) upd_q <= 1'b0;
    else if (upd_set) upd_q <= 1'b1;
  end
endmodule

// File: rtl/rp_readmux.sv
module rp_readmux
  import dma_regport_pkg::*;
(
  input  logic                  en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  hi,
  input  logic [NREG*REG_W-1:0] chan_rd,
  input  logic [DATA_W-1:0]     stat,
  output logic [DATA_W-1:0]     data
);
  logic [REG_W-1:0] regs [NREG];
  logic [REG_W-1:0] pick;

  for (genvar g = 0; g < NREG; g++) begin : g_slice
    assign regs[g] = chan_rd[g*REG_W +: REG_W];
  end

  assign pick = regs[addr[RIDX_W-1:0]];

  always_comb begin
    data = '0;
    if (en) begin
      unique case (tgt_of(addr))
        TGT_CHAN: data = hi ? pick[REG_W-1:DATA_W] : pick[DATA_W-1:0];
        TGT_GEN:  data = stat;
        default:  data = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_regport.sv
module dma_regport
  import dma_regport_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  ior_n,
  input  logic                  iow_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     data_i,
  input  logic                  master_i,
  input  logic [CH_N-1:0]       tc_hit_i,
  input  logic                  upd_set_i,
  input  logic                  upd_clr_i,
  input  logic [NREG*REG_W-1:0] chan_rd_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  rd_oe_o,
  output logic [NREG-1:0]       reg_we_o,
  output logic                  reg_hi_o,
  output logic [DATA_W-1:0]     reg_wdata_o,
  output logic [DATA_W-1:0]     mode_o
);
  localparam int AL_BIT = DATA_W - 1;

  logic              sel_wr, sel_rd;
  logic              wr_done, rd_done;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data_q;
  tgt_e              wr_tgt, rd_tgt;
  logic              ptr_q;
  logic [DATA_W-1:0] mode_q;
  logic [CH_N-1:0]   tc_q;
  logic              upd_q;
  logic              mode_wr, chan_acc, upd_clr_all;
  logic [DATA_W-1:0] stat_byte;

  // host access qualification: chip select is ignored while bus master
  assign sel_wr = !cs_n && !iow_n && ior_n && !master_i;
  assign sel_rd = !cs_n && !ior_n && iow_n && !master_i;

  rp_access u_wr (
    .clk(clk), .rst_n(rst_n), .sel(sel_wr), .strobe_n(iow_n),
    .addr_i(addr_i), .addr_q(wr_addr), .done(wr_done)
  );

  rp_access u_rd (
    .clk(clk), .rst_n(rst_n), .sel(sel_rd), .strobe_n(ior_n),
    .addr_i(addr_i), .addr_q(rd_addr), .done(rd_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_data_q <= '0;
    else if (sel_wr) wr_data_q <= data_i;
  end

  assign wr_tgt   = tgt_of(wr_addr);
  assign rd_tgt   = tgt_of(rd_addr);
  assign mode_wr  = wr_done && (wr_tgt == TGT_GEN);
  assign chan_acc = (wr_done && (wr_tgt == TGT_CHAN)) ||
                    (rd_done && (rd_tgt == TGT_CHAN));

  // byte pointer: mode write clears, channel access toggles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= 1'b0;
    else if (mode_wr)  ptr_q <= 1'b0;
    else if (chan_acc) ptr_q <= ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= wr_data_q;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign reg_we_o[g] = wr_done && (wr_tgt == TGT_CHAN) &&
                         (wr_addr[RIDX_W-1:0] == RIDX_W'(g));
  end

  assign upd_clr_all = upd_clr_i || (mode_wr && !wr_data_q[AL_BIT]);

  rp_status u_stat (
    .clk(clk), .rst_n(rst_n), .tc_hit(tc_hit_i),
    .tc_clr(rd_done && (rd_tgt == TGT_GEN)),
    .upd_set(upd_set_i), .upd_clr(upd_clr_all),
    .tc_q(tc_q), .upd_q(upd_q)
  );

  assign stat_byte = {{(DATA_W-CH_N-1){1'b0}}, upd_q, tc_q};

  rp_readmux u_rmux (
    .en(sel_rd), .addr(addr_i), .hi(ptr_q), .chan_rd(chan_rd_i),
    .stat(stat_byte), .data(rd_data_o)
  );

  assign rd_oe_o     = sel_rd;
  assign reg_hi_o    = ptr_q;
  assign reg_wdata_o = wr_data_q;
  assign mode_o      = mode_q;
endmodule

// File: rtl/dma_regport_chk.sv
module dma_regport_chk
  import dma_regport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              iow_n,
  input logic              master_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_oe_o,
  input logic [NREG-1:0]   reg_we_o,
  input logic [DATA_W-1:0] mode_o
);
  p_we_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_we_o));

  p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o != '0) |=> (reg_we_o == '0));

  p_mode_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> ($past(iow_n) && !$past(iow_n, 2)));

  p_master_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && $past(master_i)) |-> ((reg_we_o == '0) && !rd_oe_o));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe_o |-> (rd_data_o == '0));

  p_stat_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe_o && addr_i == 4'b1000) |-> (rd_data_o[DATA_W-1:CH_N+1] == '0));
endmodule

bind dma_regport dma_regport_chk u_chk (.*);

// File: tb/test_dma_regport.sv
module test_dma_regport;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cs_n, ior_n, iow_n, master_i;
  logic [3:0]   addr_i;
  logic [7:0]   data_i;
  logic [3:0]   tc_hit_i;
  logic         upd_set_i, upd_clr_i;
  logic [127:0] chan_rd_i;
  logic [7:0]   rd_data_o, reg_wdata_o, mode_o;
  logic         rd_oe_o, reg_hi_o;
  logic [7:0]   reg_we_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model
  logic        ptr_m;
  logic [7:0]  mode_m;
  logic [3:0]  tc_m;
  logic        upd_m;
  logic [15:0] chm [8];

  always #10 clk = ~clk;

  dma_regport i_dma_regport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ior_n(ior_n), .iow_n(iow_n),
    .addr_i(addr_i), .data_i(data_i), .master_i(master_i),
    .tc_hit_i(tc_hit_i), .upd_set_i(upd_set_i), .upd_clr_i(upd_clr_i),
    .chan_rd_i(chan_rd_i), .rd_data_o(rd_data_o), .rd_oe_o(rd_oe_o),
    .reg_we_o(reg_we_o), .reg_hi_o(reg_hi_o), .reg_wdata_o(reg_wdata_o),
    .mode_o(mode_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic new_regs();
    for (int k = 0; k < 8; k++) begin
      chm[k] = 16'($urandom);
      chan_rd_i[k*16 +: 16] = chm[k];
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (!a[3])          return ptr_m ? chm[a[2:0]][15:8] : chm[a[2:0]][7:0];
    else if (a == 4'h8) return {3'b000, upd_m, tc_m};
    else                return 8'h00;
  endfunction

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d, input int hold, input string req);
    logic [7:0] we_exp;
    @(negedge clk);
    addr_i = a; data_i = d; cs_n = 1'b0; iow_n = 1'b0;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk); #1;
      check("R3", reg_we_o, 8'h00);
    end
    iow_n = 1'b1;
    #1;
    we_exp = (!a[3] && !master_i) ? (8'h01 << a[2:0]) : 8'h00;
    check(req, reg_we_o, we_exp);
    if (we_exp != 0) begin
      check("R2", reg_wdata_o, d);
      check("R3", reg_hi_o, ptr_m);
    end
    if (!master_i) begin
      if (!a[3]) ptr_m = ~ptr_m;
      else if (a == 4'h8) begin
        mode_m = d; ptr_m = 1'b0;
        if (!d[7]) upd_m = 1'b0;
      end
    end
    @(negedge clk);
    cs_n = 1'b1;
    #1;
    check(req, mode_o, mode_m);
    check("R2", reg_we_o, 8'h00);
  endtask

  task automatic do_rd(input logic [3:0] a, input int hold, input logic [3:0] tc_end, input string req);
    @(negedge clk);
    addr_i = a; cs_n = 1'b0; ior_n = 1'b0;
    #1;
    check("R10", rd_oe_o, !master_i);
    check(req, rd_data_o, master_i ? 8'h00 : exp_rd(a));
    for (int h = 1; h < hold; h++) @(negedge clk);
    @(negedge clk); #1;
    ior_n = 1'b1; tc_hit_i = tc_end;
    if (!master_i) begin
      if (!a[3]) ptr_m = ~ptr_m;
      else if (a == 4'h8) tc_m = 4'h0;
    end
    tc_m = tc_m | tc_end;
    @(negedge clk);
    tc_hit_i = 4'h0; cs_n = 1'b1;
  endtask

  task automatic pulse_ev(input logic [3:0] tc, input logic us, input logic uc);
    @(negedge clk);
    tc_hit_i = tc; upd_set_i = us; upd_clr_i = uc;
    @(negedge clk);
    tc_hit_i = 4'h0; upd_set_i = 1'b0; upd_clr_i = 1'b0;
    tc_m = tc_m | tc;
    if (uc) upd_m = 1'b0;
    else if (us) upd_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cs_n = 1'b1; ior_n = 1'b1; iow_n = 1'b1; master_i = 1'b0;
    addr_i = 4'h0; data_i = 8'h00; tc_hit_i = 4'h0; upd_set_i = 1'b0; upd_clr_i = 1'b0;
    chan_rd_i = '0;
    ptr_m = 1'b0; mode_m = 8'h00; tc_m = 4'h0; upd_m = 1'b0;
    new_regs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1", mode_o, 8'h00);
    check("R1", reg_we_o, 8'h00);
    check("R1", rd_oe_o, 1'b0);
    do_rd(4'h8, 1, 4'h0, "R1");
    do_rd(4'h3, 1, 4'h0, "R1");
    do_rd(4'h3, 1, 4'h0, "R5");

    // R2 / R3 channel writes with long holds
    do_wr(4'h0, 8'h5A, 1, "R2");
    do_wr(4'h0, 8'hC3, 4, "R2");
    do_wr(4'h7, 8'h11, 2, "R2");
    do_rd(4'h6, 3, 4'h0, "R3");

    // R4 mode write clears the pointer mid-pair
    do_wr(4'h4, 8'h22, 1, "R2");
    do_wr(4'h8, 8'h35, 1, "R4");
    do_wr(4'h5, 8'h44, 1, "R4");
    do_rd(4'h5, 1, 4'h0, "R5");

    // R6 / R7 sticky flags
    pulse_ev(4'h9, 1'b0, 1'b0);
    do_rd(4'h8, 1, 4'h0, "R7");
    do_rd(4'h8, 1, 4'h0, "R6");
    pulse_ev(4'h1, 1'b0, 1'b0);
    do_rd(4'h8, 2, 4'h2, "R7");
    do_rd(4'h8, 1, 4'h0, "R7");

    // R8 update flag
    pulse_ev(4'h0, 1'b1, 1'b0);
    do_rd(4'h8, 1, 4'h0, "R8");
    do_rd(4'h8, 1, 4'h0, "R8");
    do_wr(4'h8, 8'h81, 1, "R8");
    do_rd(4'h8, 1, 4'h0, "R8");
    do_wr(4'h8, 8'h0F, 1, "R8");
    do_rd(4'h8, 1, 4'h0, "R8");
    pulse_ev(4'h0, 1'b1, 1'b1);
    do_rd(4'h8, 1, 4'h0, "R8");

    // R9 bus-master ignore
    do_wr(4'h2, 8'h10, 1, "R2");
    @(negedge clk); master_i = 1'b1;
    do_wr(4'h3, 8'h77, 1, "R9");
    do_wr(4'h8, 8'hFF, 1, "R9");
    do_rd(4'h3, 1, 4'h0, "R9");
    @(negedge clk); master_i = 1'b0;
    do_rd(4'h1, 1, 4'h0, "R9");

    // R10 no enable without chip select
    @(negedge clk);
    cs_n = 1'b1; ior_n = 1'b0; addr_i = 4'h8;
    #1;
    check("R10", rd_oe_o, 1'b0);
    check("R10", rd_data_o, 8'h00);
    @(negedge clk); ior_n = 1'b1;

    // R11 unused general addresses
    do_wr(4'h0, 8'h01, 1, "R2");
    do_wr(4'hB, 8'hEE, 1, "R11");
    do_rd(4'hD, 1, 4'h0, "R11");
    do_rd(4'h0, 1, 4'h0, "R11");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      int hold;
      logic [3:0] a;
      op = $urandom_range(0, 9);
      hold = $urandom_range(1, 3);
      if (n % 16 == 0) new_regs();
      case (op)
        0, 1, 2: begin a = {1'b0, 3'($urandom)}; do_wr(a, 8'($urandom), hold, "R2"); end
        3, 4, 5: begin a = {1'b0, 3'($urandom)}; do_rd(a, hold, 4'h0, "R5"); end
        6:       do_rd(4'h8, hold, 4'($urandom), "R6");
        7:       pulse_ev(4'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
        8:       begin a = {1'b1, 3'($urandom)}; do_rd(a, hold, 4'h0, "R11"); end
        default: begin
          a = ($urandom_range(0, 1) == 0) ? 4'h8 : {1'b1, 3'($urandom)};
          do_wr(a, 8'($urandom), hold, (a == 4'h8) ? "R4" : "R11");
        end
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule